// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block lets several processor ports share one word-addressed memory while supporting lock-free read-modify-write sequences. Each port may issue a load-linked, a store-conditional or a plain store in any cycle. A load-linked returns the memory word and records a reservation (address plus valid flag) for that port. A later store-conditional from the same port writes memory only if that reservation is still intact, and it reports success as 1 or failure as 0. Any write to a reserved word, from any port, cancels the reservation, so a store-conditional fails whenever another write came between it and its load-linked.

Requests that arrive in the same cycle are put in order by port index: port 0 first, then port 1, and so on. A load-linked in a cycle reads the memory contents from before that cycle's writes. Its reservation does not survive if any port writes that word in the same cycle. A single clear input cancels every reservation at once. This lets the surrounding system force retries, for example after an exception.

Top module: `lsc_monitor`

## Requirements
- R1: Op codes per port are 2'b00 idle, 2'b01 load-linked, 2'b10 store-conditional, 2'b11 store. Every non-idle request produces rsp_valid exactly one cycle later. An idle one produces none. A load-linked response carries the word stored at its address.
- R2: A store-conditional whose port holds a valid reservation for the same address, with no write to that word in between, writes its data to memory and returns 1.
- R3: A failed store-conditional returns 0 and leaves memory unchanged.
- R4: A plain store always writes memory and returns 0. Any write (a store or a successful store-conditional) cancels every reservation on that address, the writer's own included.
- R5: Each port holds one reservation. A new load-linked replaces the previous one, so a store-conditional to the older address fails.
- R6: A store-conditional cancels its own port's reservation whether it succeeds or fails.
- R7: A store-conditional to an address other than the reserved one fails.
- R8: Same-cycle requests are ordered by ascending port index. A store-conditional on port i fails if a lower-indexed port writes the same word in that cycle. When several ports write one word, the highest-indexed value remains. At most one of several same-cycle store-conditionals to one word succeeds.
- R9: A load-linked issued in the same cycle as a write to its word returns the old value and keeps no valid reservation.
- R10: Asserting clear_i cancels all reservations, including one that a load-linked in the same cycle would have set.
- R11: After reset no response is valid and no port holds a reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_i | input | 1 | Cancel all reservations |
| req_op_i | input | 2*NPORTS | Per-port op code, port p at bits [2p+1:2p] |
| req_addr_i | input | AW*NPORTS | Per-port word address |
| req_wdata_i | input | DW*NPORTS | Per-port write data |
| rsp_valid_o | output | NPORTS | Response valid, one cycle after a request |
| rsp_data_o | output | DW*NPORTS | Loaded word, store-conditional result (1/0), or 0 for a store |

## Verification
On every cycle, the assertions check the local rules. A response appears exactly when a request came one cycle earlier. A successful store-conditional always had a matching valid reservation. A store-conditional always drops its port's reservation. Stores return zero. Clear empties every reservation. Two same-cycle store-conditionals to one word never both succeed. Whether memory ends up holding the right value is a property of whole sequences, so only the bench's scenarios and its model-compared pseudo-random sweep can show it. The same holds for intervening writes that defeat a later store-conditional and for same-cycle orderings.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_LL   = 2'b01,
    OP_SC   = 2'b10,
    OP_ST   = 2'b11
  } lsc_op_e;
endpackage

// File: rtl/lsc_resv_slot.sv
// One port's reservation: address plus valid flag.
module lsc_resv_slot #(
  parameter int NPORTS = 4,
  parameter int AW     = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear_i,
  input  logic [1:0]           op_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [NPORTS-1:0]    wr_en_i,
  input  logic [NPORTS*AW-1:0] wr_addr_i,
  output logic                 valid_o,
  output logic [AW-1:0]        addr_o
);
  import lsc_pkg::*;

  logic hit_new;
  logic hit_held;

  // Does any write this cycle land on the new or the held address?
  always_comb begin
    hit_new  = 1'b0;
    hit_held = 1'b0;
    for (int j = 0; j < NPORTS; j++) begin
      if (wr_en_i[j] && wr_addr_i[j*AW +: AW] == addr_i) hit_new  = 1'b1;
      if (wr_en_i[j] && wr_addr_i[j*AW +: AW] == addr_o) hit_held = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
    end else begin
      if (op_i == OP_LL) addr_o <= addr_i;
      if (clear_i)              valid_o <= 1'b0;
      else if (op_i == OP_LL)   valid_o <= !hit_new;
      else if (op_i == OP_SC)   valid_o <= 1'b0;
      else if (hit_held)        valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/lsc_arbiter.sv
// Serialises same-cycle requests in ascending port order and decides writes.
module lsc_arbiter #(
  parameter int NPORTS = 4,
  parameter int AW     = 6
) (
  input  logic [NPORTS*2-1:0]  op_i,
  input  logic [NPORTS*AW-1:0] addr_i,
  input  logic [NPORTS-1:0]    resv_valid_i,
  input  logic [NPORTS*AW-1:0] resv_addr_i,
  output logic [NPORTS-1:0]    wr_en_o,
  output logic [NPORTS-1:0]    sc_ok_o
);
  import lsc_pkg::*;

  logic [NPORTS-1:0] wr_l;
  logic [NPORTS-1:0] ok_l;

  always_comb begin
    wr_l = '0;
    ok_l = '0;
    for (int i = 0; i < NPORTS; i++) begin
      logic blocked;
      blocked = 1'b0;
      for (int j = 0; j < NPORTS; j++) begin
        if (j < i && wr_l[j] && addr_i[j*AW +: AW] == addr_i[i*AW +: AW])
          blocked = 1'b1;
      end
      if (op_i[i*2 +: 2] == OP_SC)
        ok_l[i] = resv_valid_i[i] && !blocked &&
                  (resv_addr_i[i*AW +: AW] == addr_i[i*AW +: AW]);
      wr_l[i] = (op_i[i*2 +: 2] == OP_ST) || ok_l[i];
    end
    wr_en_o = wr_l;
    sc_ok_o = ok_l;
  end
endmodule

// File: rtl/lsc_store.sv
// Shared word memory: one write lane per port (later lanes win), registered reads.
module lsc_store #(
  parameter int NPORTS = 4,
  parameter int AW     = 6,
  parameter int DW     = 32
) (
  input  logic                 clk,
  input  logic [NPORTS-1:0]    wr_en_i,
  input  logic [NPORTS*AW-1:0] addr_i,
  input  logic [NPORTS*DW-1:0] wdata_i,
  output logic [NPORTS*DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPORTS; i++) begin
      if (wr_en_i[i]) mem[addr_i[i*AW +: AW]] <= wdata_i[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NPORTS; i++) begin
      rdata_o[i*DW +: DW] <= mem[addr_i[i*AW +: AW]];
    end
  end
endmodule

// File: rtl/lsc_monitor.sv
module lsc_monitor #(
  parameter int NPORTS = 4,
  parameter int AW     = 6,
  parameter int DW     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clear_i,
  input  logic [NPORTS*2-1:0]  req_op_i,
  input  logic [NPORTS*AW-1:0] req_addr_i,
  input  logic [NPORTS*DW-1:0] req_wdata_i,
  output logic [NPORTS-1:0]    rsp_valid_o,
  output logic [NPORTS*DW-1:0] rsp_data_o
);
  import lsc_pkg::*;

  logic [NPORTS-1:0]    resv_valid;
  logic [NPORTS*AW-1:0] resv_addr;
  logic [NPORTS-1:0]    wr_en;
  logic [NPORTS-1:0]    sc_ok;
  logic [NPORTS*DW-1:0] rd_data;

  logic [NPORTS-1:0]    is_ll_q;
  logic [NPORTS-1:0]    is_sc_q;
  logic [NPORTS-1:0]    sc_ok_q;

  for (genvar p = 0; p < NPORTS; p++) begin : g_slot
    lsc_resv_slot #(.NPORTS(NPORTS), .AW(AW)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .clear_i  (clear_i),
      .op_i     (req_op_i[p*2 +: 2]),
      .addr_i   (req_addr_i[p*AW +: AW]),
      .wr_en_i  (wr_en),
      .wr_addr_i(req_addr_i),
      .valid_o  (resv_valid[p]),
      .addr_o   (resv_addr[p*AW +: AW])
    );
  end

  lsc_arbiter #(.NPORTS(NPORTS), .AW(AW)) u_arb (
    .op_i        (req_op_i),
    .addr_i      (req_addr_i),
    .resv_valid_i(resv_valid),
    .resv_addr_i (resv_addr),
    .wr_en_o     (wr_en),
    .sc_ok_o     (sc_ok)
  );

  lsc_store #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_mem (
    .clk    (clk),
    .wr_en_i(wr_en),
    .addr_i (req_addr_i),
    .wdata_i(req_wdata_i),
    .rdata_o(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_o <= '0;
      is_ll_q     <= '0;
      is_sc_q     <= '0;
      sc_ok_q     <= '0;
    end else begin
      for (int p = 0; p < NPORTS; p++) begin
        rsp_valid_o[p] <= req_op_i[p*2 +: 2] != OP_IDLE;
        is_ll_q[p]     <= req_op_i[p*2 +: 2] == OP_LL;
        is_sc_q[p]     <= req_op_i[p*2 +: 2] == OP_SC;
      end
      sc_ok_q <= sc_ok;
    end
  end

  always_comb begin
    for (int p = 0; p < NPORTS; p++) begin
      if (is_ll_q[p])      rsp_data_o[p*DW +: DW] = rd_data[p*DW +: DW];
      else if (is_sc_q[p]) rsp_data_o[p*DW +: DW] = {{(DW-1){1'b0}}, sc_ok_q[p]};
      else                 rsp_data_o[p*DW +: DW] = '0;
    end
  end
endmodule

// File: rtl/lsc_monitor_chk.sv
module lsc_monitor_chk #(
  parameter int NPORTS = 4,
  parameter int AW     = 6,
  parameter int DW     = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 clear_i,
  input logic [NPORTS*2-1:0]  req_op_i,
  input logic [NPORTS*AW-1:0] req_addr_i,
  input logic [NPORTS-1:0]    rsp_valid_o,
  input logic [NPORTS*DW-1:0] rsp_data_o,
  input logic [NPORTS-1:0]    resv_valid,
  input logic [NPORTS*AW-1:0] resv_addr
);
  AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (rst)
    $past(clear_i) |-> resv_valid == '0); // R10

  for (genvar i = 0; i < NPORTS; i++) begin : g_port
    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
      $past(req_op_i[i*2 +: 2] != 2'b00) |-> rsp_valid_o[i]); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (rst)
      rsp_valid_o[i] |-> $past(req_op_i[i*2 +: 2] != 2'b00)); // R1
    AST_SC_WIN_HAD_RESV: assert property (@(posedge clk) disable iff (rst)
      ($past(req_op_i[i*2 +: 2] == 2'b10) && rsp_data_o[i*DW]) |->
      $past(resv_valid[i] && resv_addr[i*AW +: AW] == req_addr_i[i*AW +: AW])); // R2
    AST_SC_DROPS_RESV: assert property (@(posedge clk) disable iff (rst)
      $past(req_op_i[i*2 +: 2] == 2'b10) |-> !resv_valid[i]); // R6
    AST_ST_RSP_ZERO: assert property (@(posedge clk) disable iff (rst)
      $past(req_op_i[i*2 +: 2] == 2'b11) |-> rsp_data_o[i*DW +: DW] == '0); // R4
    for (genvar j = i + 1; j < NPORTS; j++) begin : g_pair
      AST_SC_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
        $past(req_op_i[i*2 +: 2] == 2'b10 && req_op_i[j*2 +: 2] == 2'b10 &&
              req_addr_i[i*AW +: AW] == req_addr_i[j*AW +: AW]) |->
        !(rsp_data_o[i*DW] && rsp_data_o[j*DW])); // R8
    end
  end
endmodule

bind lsc_monitor lsc_monitor_chk #(.NPORTS(NPORTS), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clear_i    (clear_i),
  .req_op_i   (req_op_i),
  .req_addr_i (req_addr_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_data_o (rsp_data_o),
  .resv_valid (resv_valid),
  .resv_addr  (resv_addr)
);

// File: tb/lsc_monitor_bench.sv
module lsc_monitor_bench;
  localparam int NP = 3;
  localparam int AW = 2;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst;
  logic             clear_i;
  logic [NP*2-1:0]  req_op_i;
  logic [NP*AW-1:0] req_addr_i;
  logic [NP*DW-1:0] req_wdata_i;
  logic [NP-1:0]    rsp_valid_o;
  logic [NP*DW-1:0] rsp_data_o;

  lsc_monitor #(.NPORTS(NP), .AW(AW), .DW(DW)) u_lsc_monitor (
    .clk(clk), .rst(rst), .clear_i(clear_i), .req_op_i(req_op_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o)
  );

  int vectors = 0;
  int fails   = 0;

  logic [1:0]    op_t [NP];
  logic [AW-1:0] ad_t [NP];
  logic [DW-1:0] wd_t [NP];
  logic          clr_t;

  logic [DW-1:0] mem_m [DEPTH];
  logic          rv_m  [NP];
  logic [AW-1:0] ra_m  [NP];
  logic [DW-1:0] got_d [NP];
  string         tag;

  task automatic chk(input string t, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  task automatic idle_all();
    for (int p = 0; p < NP; p++) begin
      op_t[p] = 2'b00; ad_t[p] = '0; wd_t[p] = '0;
    end
    clr_t = 1'b0;
  endtask

  task automatic put(input int p, input logic [1:0] op, input int a, input logic [DW-1:0] d);
    op_t[p] = op; ad_t[p] = AW'(a); wd_t[p] = d;
  endtask

  // One cycle: drive, predict from the reference model, compare after the edge.
  task automatic cycle();
    logic [DW-1:0] old_m [DEPTH];
    logic          wr_b  [NP];
    logic          exp_v [NP];
    logic [DW-1:0] exp_d [NP];
    for (int p = 0; p < NP; p++) begin
      req_op_i[p*2 +: 2]     = op_t[p];
      req_addr_i[p*AW +: AW] = ad_t[p];
      req_wdata_i[p*DW +: DW] = wd_t[p];
    end
    clear_i = clr_t;
    for (int a = 0; a < DEPTH; a++) old_m[a] = mem_m[a];
    for (int i = 0; i < NP; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < i; j++) if (wr_b[j] && ad_t[j] == ad_t[i]) blk = 1'b1;
      wr_b[i]  = 1'b0;
      exp_v[i] = op_t[i] != 2'b00;
      exp_d[i] = '0;
      case (op_t[i])
        2'b01: exp_d[i] = old_m[ad_t[i]];
        2'b10: begin
          wr_b[i]  = rv_m[i] && ra_m[i] == ad_t[i] && !blk;
          exp_d[i] = DW'(wr_b[i]);
        end
        2'b11: wr_b[i] = 1'b1;
        default: ;
      endcase
    end
    for (int i = 0; i < NP; i++) if (wr_b[i]) mem_m[ad_t[i]] = wd_t[i];
    for (int i = 0; i < NP; i++) begin
      logic k_new, k_old;
      k_new = 1'b0; k_old = 1'b0;
      for (int j = 0; j < NP; j++) begin
        if (wr_b[j] && ad_t[j] == ad_t[i]) k_new = 1'b1;
        if (wr_b[j] && ad_t[j] == ra_m[i]) k_old = 1'b1;
      end
      if (op_t[i] == 2'b01) ra_m[i] = ad_t[i];
      if (clr_t)                rv_m[i] = 1'b0;
      else if (op_t[i] == 2'b01) rv_m[i] = !k_new;
      else if (op_t[i] == 2'b10) rv_m[i] = 1'b0;
      else if (k_old)            rv_m[i] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      got_d[p] = rsp_data_o[p*DW +: DW];
      chk({tag, " R1 valid"}, DW'(rsp_valid_o[p]), DW'(exp_v[p]));
      if (exp_v[p]) chk({tag, " model data"}, got_d[p], exp_d[p]);
    end
    idle_all();
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  logic [15:0] lf;

  initial begin
    idle_all();
    for (int a = 0; a < DEPTH; a++) mem_m[a] = '0;
    for (int p = 0; p < NP; p++) begin rv_m[p] = 1'b0; ra_m[p] = '0; end
    rst = 1'b1; clear_i = 1'b0; req_op_i = '0; req_addr_i = '0; req_wdata_i = '0;
    repeat (3) @(negedge clk);
    chk("R11 no response in reset", DW'(rsp_valid_o), '0);
    rst = 1'b0;

    tag = "R11";
    put(0, 2'b10, 0, 8'h77); cycle();
    chk("R11 SC without LL after reset", got_d[0], 8'h00);

    tag = "init";
    put(0, 2'b11, 0, 8'h10); put(1, 2'b11, 1, 8'h21); put(2, 2'b11, 2, 8'h32); cycle();
    chk("R4 store returns 0", got_d[1], 8'h00);
    put(0, 2'b11, 3, 8'h43); cycle();

    tag = "R1";
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < DEPTH; a++) begin
        put(p, 2'b01, a, '0); cycle();
        chk("R1 LL data", got_d[p], DW'(a * 17 + 16));
      end

    tag = "R2";
    for (int p = 0; p < NP; p++)
      for (int a = 0; a < DEPTH; a++) begin
        put(p, 2'b01, a, '0); cycle();
        put(p, 2'b10, a, DW'(8'h80 + p * 16 + a)); cycle();
        chk("R2 SC success", got_d[p], 8'h01);
        put((p + 1) % NP, 2'b01, a, '0); cycle();
        chk("R2 memory written", got_d[(p + 1) % NP], DW'(8'h80 + p * 16 + a));
      end

    tag = "R3";
    put(0, 2'b01, 1, '0); cycle();
    put(1, 2'b11, 1, 8'h5A); cycle();
    chk("R4 store response", got_d[1], 8'h00);
    put(0, 2'b10, 1, 8'hEE); cycle();
    chk("R3 SC fails after other write", got_d[0], 8'h00);
    put(2, 2'b01, 1, '0); cycle();
    chk("R3 memory unchanged", got_d[2], 8'h5A);

    tag = "R4";
    put(2, 2'b01, 0, '0); cycle();
    put(2, 2'b11, 0, 8'h00); cycle();
    put(2, 2'b10, 0, 8'h99); cycle();
    chk("R4 own store cancels", got_d[2], 8'h00);

    tag = "R5";
    put(1, 2'b01, 0, '0); cycle();
    put(1, 2'b01, 2, '0); cycle();
    put(1, 2'b10, 0, 8'h11); cycle();
    chk("R5 old reservation replaced", got_d[1], 8'h00);
    put(1, 2'b01, 2, '0); cycle();
    put(1, 2'b10, 2, 8'h62); cycle();
    chk("R5 new reservation works", got_d[1], 8'h01);

    tag = "R6";
    put(2, 2'b01, 3, '0); cycle();
    put(2, 2'b10, 3, 8'h63); cycle();
    chk("R6 first SC", got_d[2], 8'h01);
    put(2, 2'b10, 3, 8'h64); cycle();
    chk("R6 second SC fails", got_d[2], 8'h00);

    tag = "R7";
    put(0, 2'b01, 2, '0); cycle();
    put(0, 2'b10, 3, 8'h70); cycle();
    chk("R7 wrong address SC", got_d[0], 8'h00);
    put(0, 2'b01, 3, '0); cycle();
    chk("R7 memory unchanged", got_d[0], 8'h63);

    tag = "R8";
    put(0, 2'b01, 0, '0); put(1, 2'b01, 0, '0); put(2, 2'b01, 0, '0); cycle();
    put(0, 2'b10, 0, 8'hA0); put(1, 2'b10, 0, 8'hA1); put(2, 2'b10, 0, 8'hA2); cycle();
    chk("R8 port0 wins", got_d[0], 8'h01);
    chk("R8 port1 loses", got_d[1], 8'h00);
    chk("R8 port2 loses", got_d[2], 8'h00);
    put(1, 2'b01, 0, '0); cycle();
    chk("R8 winner data", got_d[1], 8'hA0);
    put(0, 2'b11, 1, 8'hB0); put(1, 2'b11, 1, 8'hB1); put(2, 2'b11, 1, 8'hB2); cycle();
    put(0, 2'b01, 1, '0); cycle();
    chk("R8 last store stays", got_d[0], 8'hB2);
    put(2, 2'b01, 1, '0); cycle();
    put(0, 2'b11, 1, 8'hC0); put(2, 2'b10, 1, 8'hC2); cycle();
    chk("R8 lower write blocks SC", got_d[2], 8'h00);
    put(0, 2'b01, 2, '0); cycle();
    put(0, 2'b10, 2, 8'hD0); put(1, 2'b11, 2, 8'hD1); cycle();
    chk("R8 SC before higher store", got_d[0], 8'h01);
    put(2, 2'b01, 2, '0); cycle();
    chk("R8 higher store lands last", got_d[2], 8'hD1);

    tag = "R9";
    put(0, 2'b01, 3, '0); put(1, 2'b11, 3, 8'hE3); cycle();
    chk("R9 LL sees old value", got_d[0], 8'h63);
    put(0, 2'b10, 3, 8'hE4); cycle();
    chk("R9 reservation not kept", got_d[0], 8'h00);

    tag = "R10";
    put(0, 2'b01, 0, '0); put(1, 2'b01, 1, '0); cycle();
    clr_t = 1'b1; cycle();
    put(0, 2'b10, 0, 8'hF0); put(1, 2'b10, 1, 8'hF1); cycle();
    chk("R10 port0 cleared", got_d[0], 8'h00);
    chk("R10 port1 cleared", got_d[1], 8'h00);
    put(2, 2'b01, 2, '0); clr_t = 1'b1; cycle();
    put(2, 2'b10, 2, 8'hF2); cycle();
    chk("R10 clear beats LL", got_d[2], 8'h00);

    tag = "R8 sweep";
    lf = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < NP; p++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        put(p, lf[1:0], int'(lf[3:2]) & 1, lf[11:4]);
      end
      clr_t = (lf[15:12] == 4'h0);
      cycle();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule